// File: doc/BRIEF.md
# Dual-Processor Mailbox with Cross-Wired Word Queues

This block joins two processors, called side A and side B, through a pair of one-way word queues and a small set of registers. Each side pushes 32-bit words into its own 16-entry queue. The other side pops them from its receive port, so each queue carries traffic in one direction only. Each side also has a control register with queue status, interrupt enables, a sticky error flag, a queue-clear action and a master enable. A sync register lets each side publish a 4-bit value and raise a doorbell interrupt toward the other side.

Both sides use the same register interface. Each side has a 2-bit register select, write and read strobes, four byte enables and 32-bit write data. It also has combinational read data, one level interrupt output and an acknowledge input. The register select encodes: 0 = sync, 1 = control, 2 = send port (write), 3 = receive port (read). A read strobe applied to the receive port pops the queue at the clock edge. The data returned in that cycle is the head word before the pop.

Top module: `mbx_top`

## Requirements
- R1: Each queue holds at most 16 words. In a side's control register, bit 0 is its own send queue empty, bit 1 is send queue full (exactly 16 words), bit 8 is its receive queue empty and bit 9 is receive queue full.
- R2: Words sent by side A are read by side B in the order they were sent, and words sent by side B are read by side A in the same way.
- R3: While a side's control bit 15 (enable) is 0, its send-port writes are ignored. Its receive-port reads return the head word without removing it.
- R4: A receive read while the incoming queue is empty returns 0 and sets that side's error flag (control bit 14). A send write while its own queue is full drops the word and also sets the error flag.
- R5: Writing 1 to control bit 14 clears the error flag. Writing 0 to it leaves the flag unchanged.
- R6: Writing 1 to control bit 3 empties that side's own send queue in one cycle. The clear wins over a pop by the other side in the same cycle. Bit 3 always reads 0.
- R7: Register writes change only the fields in byte lanes whose byte enable is 1. Control bits 0, 1, 8 and 9 cannot be written.
- R8: Sync bits 11:8 hold the side's writable output nibble, and sync bits 3:0 show the other side's output nibble. Writes cannot change bits 3:0.
- R9: A side's interrupt is high while its send queue is empty and control bit 2 is 1. It is also high while its receive queue is not empty and control bit 10 is 1.
- R10: Writing 1 to sync bit 13 (reads 0) raises the other side's interrupt when that side's sync bit 14 is 1. The interrupt stays high until that side pulses its acknowledge input. With sync bit 14 at 0 the write has no effect.
- R11: After reset both queues are empty, all enable, error and interrupt-enable bits are 0, both nibbles are 0, and both interrupts are low.
- R12: A send write and a pop of the same queue in one cycle are judged on the queue's state before that cycle. A send into a full queue is dropped even if the other side pops in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_addr | input | 2 | Side A register select |
| a_wr | input | 1 | Side A write strobe |
| a_rd | input | 1 | Side A read strobe |
| a_be | input | 4 | Side A byte enables |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data |
| a_ack | input | 1 | Side A doorbell acknowledge |
| a_irq | output | 1 | Side A interrupt request |
| b_addr | input | 2 | Side B register select |
| b_wr | input | 1 | Side B write strobe |
| b_rd | input | 1 | Side B read strobe |
| b_be | input | 4 | Side B byte enables |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data |
| b_ack | input | 1 | Side B doorbell acknowledge |
| b_irq | output | 1 | Side B interrupt request |

## Verification
Two kinds of event can hit one queue in the same cycle. One is a push by its owner together with a pop by the other side. The other is a clear by its owner together with a pop by the other side. The bench drives both sides in one cycle to create each case. In the first, the queue starts full. The bench then expects the popped word to be the oldest one, the pushed word to be dropped, the owner's error flag to be set and the count to become 15. In the second, the queue holds three words. The bench expects the popped word to be returned in that cycle and the queue to read empty afterwards.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned REG_W = 32;

  typedef enum logic [1:0] {
    SEL_SYNC = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_SEND = 2'd2,
    SEL_RECV = 2'd3
  } reg_sel_e;

  // control register bit positions
  localparam int unsigned CB_TX_EMPTY = 0;
  localparam int unsigned CB_TX_FULL  = 1;
  localparam int unsigned CB_TXE_IE   = 2;
  localparam int unsigned CB_TX_CLR   = 3;
  localparam int unsigned CB_RX_EMPTY = 8;
  localparam int unsigned CB_RX_FULL  = 9;
  localparam int unsigned CB_RXNE_IE  = 10;
  localparam int unsigned CB_ERR      = 14;
  localparam int unsigned CB_EN       = 15;

  // sync register bit positions
  localparam int unsigned SB_IN_LO   = 0;
  localparam int unsigned SB_OUT_LO  = 8;
  localparam int unsigned SB_TRIG    = 13;
  localparam int unsigned SB_TRIG_EN = 14;
  localparam int unsigned NIB_W      = 4;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] head_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [PW-1:0] level;
  logic          ptr_en, mem_we;
  logic [AW-1:0] mem_wa;
  logic [DW-1:0] mem_q [DEPTH];

  assign level   = wr_q - rd_q;
  assign full_o  = (level == DEPTH_P);
  assign empty_o = (wr_q == rd_q);
  assign head_o  = mem_q[rd_q[AW-1:0]];

  // clear acts first; a push in the same cycle lands in the emptied queue
  always_comb begin
    wr_d   = wr_q;
    rd_d   = rd_q;
    mem_we = 1'b0;
    mem_wa = wr_q[AW-1:0];
    if (clr_i) begin
      rd_d = '0;
      wr_d = push_i ? PW'(1) : '0;
      mem_we = push_i;
      mem_wa = '0;
    end else begin
      if (push_i && !full_o) begin
        wr_d   = wr_q + PW'(1);
        mem_we = 1'b1;
      end
      if (pop_i && !empty_o) rd_d = rd_q + PW'(1);
    end
    ptr_en = clr_i | push_i | pop_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else if (ptr_en) begin
      wr_q <= wr_d;
      rd_q <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem_q[mem_wa] <= wdata_i;
  end
endmodule

// File: rtl/mbx_port.sv
module mbx_port
  import mbx_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       addr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [3:0]       be_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic             ack_i,
  input  logic             tx_empty_i,
  input  logic             tx_full_i,
  input  logic             rx_empty_i,
  input  logic             rx_full_i,
  input  logic [DW-1:0]    rx_head_i,
  input  logic [NIB_W-1:0] peer_nib_i,
  input  logic             peer_trig_i,
  output logic             push_o,
  output logic             clr_o,
  output logic             pop_o,
  output logic [NIB_W-1:0] nib_o,
  output logic             trig_o,
  output logic             trig_en_o,
  output logic             irq_o
);
  logic en_q, en_d, err_q, err_d, txe_ie_q, txe_ie_d, rxne_ie_q, rxne_ie_d;
  logic trig_en_q, trig_en_d, pend_q, pend_d;
  logic [NIB_W-1:0] nib_q, nib_d;
  logic ctrl_lo_we, ctrl_hi_we, sync_hi_we, send_wr, recv_rd;
  logic drop, underrun, err_set, err_clr;
  logic ctrl_en, sync_en, err_en, pend_en;
  logic [DW-1:0] ctrl_rd, sync_rd;

  always_comb begin
    ctrl_lo_we = wr_i && (addr_i == SEL_CTRL) && be_i[0];
    ctrl_hi_we = wr_i && (addr_i == SEL_CTRL) && be_i[1];
    sync_hi_we = wr_i && (addr_i == SEL_SYNC) && be_i[1];
    send_wr    = wr_i && (addr_i == SEL_SEND);
    recv_rd    = rd_i && (addr_i == SEL_RECV);

    txe_ie_d  = ctrl_lo_we ? wdata_i[CB_TXE_IE]  : txe_ie_q;
    rxne_ie_d = ctrl_hi_we ? wdata_i[CB_RXNE_IE] : rxne_ie_q;
    en_d      = ctrl_hi_we ? wdata_i[CB_EN]      : en_q;
    ctrl_en   = ctrl_lo_we | ctrl_hi_we;

    clr_o  = ctrl_lo_we && wdata_i[CB_TX_CLR];
    push_o = send_wr && en_q;
    pop_o  = recv_rd && en_q && !rx_empty_i;

    drop     = push_o && tx_full_i;
    underrun = recv_rd && rx_empty_i;
    err_set  = drop | underrun;
    err_clr  = ctrl_hi_we && wdata_i[CB_ERR];
    err_d    = err_set ? 1'b1 : (err_clr ? 1'b0 : err_q);
    err_en   = err_set | err_clr;

    nib_d     = sync_hi_we ? wdata_i[SB_OUT_LO +: NIB_W] : nib_q;
    trig_en_d = sync_hi_we ? wdata_i[SB_TRIG_EN]         : trig_en_q;
    sync_en   = sync_hi_we;
    trig_o    = sync_hi_we && wdata_i[SB_TRIG];

    // a new doorbell wins over an acknowledge in the same cycle
    pend_d  = (peer_trig_i && trig_en_q) ? 1'b1 : (ack_i ? 1'b0 : pend_q);
    pend_en = peer_trig_i | ack_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      txe_ie_q  <= 1'b0;
      rxne_ie_q <= 1'b0;
    end else if (ctrl_en) begin
      en_q      <= en_d;
      txe_ie_q  <= txe_ie_d;
      rxne_ie_q <= rxne_ie_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nib_q     <= '0;
      trig_en_q <= 1'b0;
    end else if (sync_en) begin
      nib_q     <= nib_d;
      trig_en_q <= trig_en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CB_TX_EMPTY] = tx_empty_i;
    ctrl_rd[CB_TX_FULL]  = tx_full_i;
    ctrl_rd[CB_TXE_IE]   = txe_ie_q;
    ctrl_rd[CB_RX_EMPTY] = rx_empty_i;
    ctrl_rd[CB_RX_FULL]  = rx_full_i;
    ctrl_rd[CB_RXNE_IE]  = rxne_ie_q;
    ctrl_rd[CB_ERR]      = err_q;
    ctrl_rd[CB_EN]       = en_q;
    sync_rd = '0;
    sync_rd[SB_IN_LO +: NIB_W]  = peer_nib_i;
    sync_rd[SB_OUT_LO +: NIB_W] = nib_q;
    sync_rd[SB_TRIG_EN]         = trig_en_q;
    unique case (addr_i)
      SEL_SYNC: rdata_o = sync_rd;
      SEL_CTRL: rdata_o = ctrl_rd;
      SEL_RECV: rdata_o = rx_empty_i ? '0 : rx_head_i;
      default:  rdata_o = '0;
    endcase
  end

  assign nib_o     = nib_q;
  assign trig_en_o = trig_en_q;
  assign irq_o     = (tx_empty_i && txe_ie_q) || (!rx_empty_i && rxne_ie_q) || pend_q;
endmodule

// File: rtl/mbx_top.sv
module mbx_top
  import mbx_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       a_addr,
  input  logic             a_wr,
  input  logic             a_rd,
  input  logic [3:0]       a_be,
  input  logic [REG_W-1:0] a_wdata,
  output logic [REG_W-1:0] a_rdata,
  input  logic             a_ack,
  output logic             a_irq,
  input  logic [1:0]       b_addr,
  input  logic             b_wr,
  input  logic             b_rd,
  input  logic [3:0]       b_be,
  input  logic [REG_W-1:0] b_wdata,
  output logic [REG_W-1:0] b_rdata,
  input  logic             b_ack,
  output logic             b_irq
);
  localparam int unsigned SIDES = 2;

  logic [1:0]       s_addr  [SIDES];
  logic [3:0]       s_be    [SIDES];
  logic [REG_W-1:0] s_wdata [SIDES];
  logic [REG_W-1:0] s_rdata [SIDES];
  logic [REG_W-1:0] fifo_head [SIDES];
  logic [NIB_W-1:0] s_nib   [SIDES];
  logic [SIDES-1:0] s_wr, s_rd, s_ack, s_irq;
  logic [SIDES-1:0] fifo_push, fifo_pop, fifo_clr, fifo_empty, fifo_full;
  logic [SIDES-1:0] s_trig, trig_en;

  assign s_addr[0]  = a_addr;   assign s_addr[1]  = b_addr;
  assign s_be[0]    = a_be;     assign s_be[1]    = b_be;
  assign s_wdata[0] = a_wdata;  assign s_wdata[1] = b_wdata;
  assign s_wr       = {b_wr, a_wr};
  assign s_rd       = {b_rd, a_rd};
  assign s_ack      = {b_ack, a_ack};
  assign a_rdata    = s_rdata[0];
  assign b_rdata    = s_rdata[1];
  assign a_irq      = s_irq[0];
  assign b_irq      = s_irq[1];

  // queue s is filled by side s and drained by the other side
  for (genvar s = 0; s < SIDES; s++) begin : g_side
    localparam int P = SIDES - 1 - s;

    mbx_fifo #(.DEPTH(DEPTH), .DW(REG_W)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (fifo_clr[s]),
      .push_i  (fifo_push[s]),
      .pop_i   (fifo_pop[P]),
      .wdata_i (s_wdata[s]),
      .head_o  (fifo_head[s]),
      .empty_o (fifo_empty[s]),
      .full_o  (fifo_full[s])
    );

    mbx_port #(.DW(REG_W)) u_port (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr_i      (s_addr[s]),
      .wr_i        (s_wr[s]),
      .rd_i        (s_rd[s]),
      .be_i        (s_be[s]),
      .wdata_i     (s_wdata[s]),
      .rdata_o     (s_rdata[s]),
      .ack_i       (s_ack[s]),
      .tx_empty_i  (fifo_empty[s]),
      .tx_full_i   (fifo_full[s]),
      .rx_empty_i  (fifo_empty[P]),
      .rx_full_i   (fifo_full[P]),
      .rx_head_i   (fifo_head[P]),
      .peer_nib_i  (s_nib[P]),
      .peer_trig_i (s_trig[P]),
      .push_o      (fifo_push[s]),
      .clr_o       (fifo_clr[s]),
      .pop_o       (fifo_pop[s]),
      .nib_o       (s_nib[s]),
      .trig_o      (s_trig[s]),
      .trig_en_o   (trig_en[s]),
      .irq_o       (s_irq[s])
    );
  end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  a_addr,
  input logic        a_wr,
  input logic [3:0]  a_be,
  input logic [31:0] a_wdata,
  input logic [1:0]  b_addr,
  input logic        b_rd,
  input logic [31:0] b_rdata,
  input logic        b_irq,
  input logic        full_a,
  input logic        empty_a,
  input logic        full_b,
  input logic        empty_b,
  input logic        trig_en_b
);
  logic a_clr, b_pop_req;
  assign a_clr     = a_wr && (a_addr == 2'd1) && a_be[0] && a_wdata[3];
  assign b_pop_req = b_rd && (b_addr == 2'd3);

  AST_EXCL_FLAGS_A: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_a && empty_a)); // R1
  AST_EXCL_FLAGS_B: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_b && empty_b)); // R1
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (b_pop_req && empty_a) |-> (b_rdata == 32'd0)); // R4
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    a_clr |=> empty_a); // R6
  AST_FULL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (full_a && !b_pop_req && !a_clr) |=> full_a); // R12
  AST_DOORBELL_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (a_wr && (a_addr == 2'd0) && a_be[1] && a_wdata[13] && trig_en_b) |=> b_irq); // R10
endmodule

bind mbx_top mbx_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .a_addr    (a_addr),
  .a_wr      (a_wr),
  .a_be      (a_be),
  .a_wdata   (a_wdata),
  .b_addr    (b_addr),
  .b_rd      (b_rd),
  .b_rdata   (b_rdata),
  .b_irq     (b_irq),
  .full_a    (fifo_full[0]),
  .empty_a   (fifo_empty[0]),
  .full_b    (fifo_full[1]),
  .empty_b   (fifo_empty[1]),
  .trig_en_b (trig_en[1])
);

// File: tb/tb_mbx_top.sv
module tb_mbx_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] RS = 2'd0, RC = 2'd1, RT = 2'd2, RR = 2'd3;

  logic clk, rst_n;
  logic [1:0] a_addr, b_addr;
  logic a_wr, a_rd, b_wr, b_rd, a_ack, b_ack, a_irq, b_irq;
  logic [3:0] a_be, b_be;
  logic [31:0] a_wdata, b_wdata, a_rdata, b_rdata;
  int n_chk, n_fail;
  bit done;

  mbx_top dut (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic idle();
    a_wr = 0; a_rd = 0; b_wr = 0; b_rd = 0;
    a_addr = 0; b_addr = 0; a_be = 0; b_be = 0; a_wdata = 0; b_wdata = 0;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input int s, input logic w, input logic [1:0] ad,
                    input logic [3:0] be, input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    if (s == 0) begin a_wr = w; a_rd = !w; a_addr = ad; a_be = be; a_wdata = d; end
    else        begin b_wr = w; b_rd = !w; b_addr = ad; b_be = be; b_wdata = d; end
    #1 q = (s == 0) ? a_rdata : b_rdata;
    @(posedge clk);
    #1 idle();
  endtask

  task automatic wr(input int s, input logic [1:0] ad, input logic [3:0] be, input logic [31:0] d);
    logic [31:0] q;
    op(s, 1'b1, ad, be, d, q);
  endtask

  task automatic rd(input int s, input logic [1:0] ad, output logic [31:0] q);
    op(s, 1'b0, ad, 4'h0, 32'h0, q);
  endtask

  task automatic rchk(input int s, input logic [1:0] ad, input logic [31:0] exp, input string req);
    logic [31:0] q;
    rd(s, ad, q);
    check(req, q, exp);
  endtask

  task automatic irq_chk(input logic ea, input logic eb, input string req);
    @(negedge clk);
    check(req, {30'd0, b_irq, a_irq}, {30'd0, eb, ea});
  endtask

  function automatic logic [31:0] word(input int k);
    return 32'hA500_0000 + 32'(k) * 32'h0001_0101;
  endfunction

  // expected control value: enable, error, receive-not-empty ie, send-empty ie, counts
  function automatic logic [31:0] ctl(input bit en, input bit er, input bit rie, input bit tie,
                                      input int tx, input int rx);
    return (32'(en) << 15) | (32'(er) << 14) | (32'(rie) << 10) | (32'(rx == 16) << 9) |
           (32'(rx == 0) << 8) | (32'(tie) << 2) | (32'(tx == 16) << 1) | 32'(tx == 0);
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] q;
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 0; a_ack = 0; b_ack = 0;
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R11 reset state
    rchk(0, RC, ctl(0,0,0,0,0,0), "R11 ctrl A");
    rchk(1, RC, ctl(0,0,0,0,0,0), "R11 ctrl B");
    rchk(1, RS, 32'h0, "R11 sync B");
    irq_chk(0, 0, "R11 irq");

    // R3 send ignored while disabled
    wr(0, RT, 4'hF, 32'hDEAD_0001);
    rchk(1, RC, ctl(0,0,0,0,0,0), "R3 disabled send ignored");

    // R7 status bits not writable
    wr(0, RC, 4'h3, 32'h0000_8303);
    wr(1, RC, 4'h3, 32'h0000_8000);
    rchk(0, RC, ctl(1,0,0,0,0,0), "R7 status read-only");

    // R1 fill sweep
    for (int k = 0; k < 16; k++) begin
      wr(0, RT, 4'hF, word(k));
      rchk(1, RC, ctl(1,0,0,0,0,k+1), "R1 receive level flags");
    end
    rchk(0, RC, ctl(1,0,0,0,16,0), "R1 send full");

    // R4 overflow, R5 error clear semantics
    wr(0, RT, 4'hF, 32'hFFFF_FFFF);
    rchk(0, RC, ctl(1,1,0,0,16,0), "R4 overflow error");
    wr(0, RC, 4'h2, 32'h0000_8000);
    rchk(0, RC, ctl(1,1,0,0,16,0), "R5 write 0 keeps error");
    wr(0, RC, 4'h2, 32'h0000_C000);
    rchk(0, RC, ctl(1,0,0,0,16,0), "R5 write 1 clears error");

    // R12 push into full queue while peer pops in the same cycle
    @(negedge clk);
    a_wr = 1; a_addr = RT; a_be = 4'hF; a_wdata = 32'h7777_7777;
    b_rd = 1; b_addr = RR;
    #1 check("R12 popped oldest", b_rdata, word(0));
    @(posedge clk);
    #1 idle();
    rchk(0, RC, ctl(1,1,0,0,15,0), "R12 push dropped, error");
    rchk(1, RC, ctl(1,0,0,0,0,15), "R12 level 15");
    wr(0, RC, 4'h2, 32'h0000_C000);

    // R2 drain in order, R4 underrun
    for (int k = 1; k < 16; k++) rchk(1, RR, word(k), "R2 order A to B");
    rchk(1, RR, 32'h0, "R4 empty read zero");
    rchk(1, RC, ctl(1,1,0,0,0,0), "R4 underrun error");
    wr(1, RC, 4'h2, 32'h0000_C000);

    // R2 reverse direction
    for (int k = 0; k < 3; k++) wr(1, RT, 4'hF, 32'hB000_0000 + 32'(k));
    for (int k = 0; k < 3; k++) rchk(0, RR, 32'hB000_0000 + 32'(k), "R2 order B to A");

    // R3 peek while disabled
    wr(0, RT, 4'hF, 32'h11);
    wr(0, RT, 4'hF, 32'h22);
    wr(1, RC, 4'h2, 32'h0000_0000);
    rchk(1, RR, 32'h11, "R3 peek first");
    rchk(1, RR, 32'h11, "R3 peek no pop");
    rchk(1, RC, ctl(0,0,0,0,0,2), "R3 level unchanged");
    wr(1, RC, 4'h2, 32'h0000_8000);
    rchk(1, RR, 32'h11, "R2 pop after enable");
    rchk(1, RR, 32'h22, "R2 pop second");

    // R6 clear
    for (int k = 0; k < 5; k++) wr(0, RT, 4'hF, word(k));
    wr(0, RC, 4'h1, 32'h0000_0008);
    rchk(0, RC, ctl(1,0,0,0,0,0), "R6 cleared, bit 3 reads 0");
    rchk(1, RC, ctl(1,0,0,0,0,0), "R6 peer sees empty");
    for (int k = 0; k < 3; k++) wr(0, RT, 4'hF, word(k + 20));
    @(negedge clk);
    a_wr = 1; a_addr = RC; a_be = 4'h1; a_wdata = 32'h0000_0008;
    b_rd = 1; b_addr = RR;
    #1 check("R6 pop during clear returns head", b_rdata, word(20));
    @(posedge clk);
    #1 idle();
    rchk(1, RC, ctl(1,0,0,0,0,0), "R6 clear wins over pop");

    // R7 byte lanes, R9 level interrupts
    wr(0, RC, 4'h1, 32'h0000_8404);
    rchk(0, RC, ctl(1,0,0,1,0,0), "R7 lane 0 only");
    irq_chk(1, 0, "R9 send-empty irq");
    wr(0, RC, 4'h2, 32'h0000_8400);
    rchk(0, RC, ctl(1,0,1,1,0,0), "R7 lane 1 only");
    wr(0, RC, 4'h1, 32'h0000_0000);
    irq_chk(0, 0, "R9 receive empty no irq");
    wr(1, RT, 4'hF, 32'h0000_0ABC);
    irq_chk(1, 0, "R9 receive not-empty irq");
    rchk(0, RR, 32'h0000_0ABC, "R2 irq word");
    irq_chk(0, 0, "R9 irq drops after pop");
    wr(0, RC, 4'hC, 32'hFFFF_0000);
    rchk(0, RC, ctl(1,0,1,0,0,0), "R7 upper lanes no effect");
    wr(0, RC, 4'h2, 32'h0000_8000);

    // R8 nibble sweep
    for (int n = 0; n < 16; n++) begin
      wr(0, RS, 4'h2, 32'(n) << 8);
      wr(0, RS, 4'h1, 32'h0000_000F);
      rchk(1, RS, 32'(n), "R8 peer input nibble");
      rchk(0, RS, 32'(n) << 8, "R8 own output, input read-only");
    end
    wr(1, RS, 4'h2, 32'h0000_0500);
    rchk(0, RS, 32'h0000_0F05, "R8 reverse nibble");

    // R10 doorbell
    wr(0, RS, 4'h2, 32'h0000_2F00);
    irq_chk(0, 0, "R10 doorbell gated off");
    wr(1, RS, 4'h2, 32'h0000_4500);
    wr(0, RS, 4'h2, 32'h0000_2F00);
    irq_chk(0, 1, "R10 doorbell raises");
    rchk(0, RS, 32'h0000_0F05, "R10 trigger reads 0");
    repeat (3) @(posedge clk);
    irq_chk(0, 1, "R10 doorbell held");
    @(negedge clk) b_ack = 1;
    @(posedge clk);
    #1 b_ack = 0;
    irq_chk(0, 0, "R10 acknowledge clears");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule